// File: doc/BRIEF.md
# Command Issue and Stall Controller

This block sits at the front of a command-stream processor. It pulls 32-bit command words one at a time from an instruction FIFO and keeps the most recent one in a code register that a host can read. It splits each word into an interrupt flag, a 7-bit command, an 8-bit count and a 16-bit immediate. Every cycle it decides whether the held word may issue. If so, it hands the command to an execution unit over a strobe/done handshake. If not, it stalls and retries.

Stalls come from three sticky status conditions: an illegal opcode, a data/tag mismatch that the execution unit reports while a command runs, and an interrupt-flagged command. Each condition has its own mask bit. A masked condition leaves its status flag clear and never stalls. An interrupt-flagged marker command still executes at once, and the stall lands on the word after it. A one-shot resume flag lets a stalled interrupt word run after the host cancels the stall, without raising a second interrupt.

The host writes a control register with two strobes: reset, which clears every flag and drops the held word, and stall-cancel, which clears the interrupt flags. It also writes a 3-bit error-mask register.

Top module: `cmd_issue_ctrl`

## Requirements
- R1: An issued command presents the word's bits 30:24 on `disp_cmd`, bits 23:16 on `disp_count` and bits 15:0 on `disp_imm`. `disp_valid` is high for exactly one cycle per command. Bit 31 is the interrupt flag and is never dispatched.
- R2: `code_word` takes every word accepted from the FIFO. `fifo_ready` is high only when no word is held and no command is outstanding, so a stalled block keeps showing the word it stopped on.
- R3: The processing state in `status[1:0]` is encoded idle=0, wait=1, decode=2, stall=3. Accepting a word in idle moves the state to decode. A dispatch moves it to wait until `disp_done`, which returns it to idle.
- R4: While any of the ER0, ER1 or PIS flags is set, no command dispatches and the state reads stall. Nothing else changes until the host clears the flag.
- R5: A new interrupt-flagged word that is not the marker command sets INT and PIS when the MII mask is clear. The block then stalls with the word still held and not dispatched.
- R6: An interrupt-flagged marker command (command value `MARK_CMD`, default 0x07) dispatches at once even with MII clear, and still sets INT and PIS. The following word is held and stalled.
- R7: With MII set (mask bit 0), an interrupt-flagged word sets INT but not PIS, and it dispatches without stalling.
- R8: A control write with bit 3 set clears PIS and INT but not ER0 or ER1. A held interrupt word then dispatches on its next issue without setting INT again.
- R9: The legal commands are 0x00–0x07, 0x10–0x15, 0x17, 0x20, 0x30, 0x31, 0x4A, 0x50, 0x51 and 0x60–0x7F. With ME1 (mask bit 2) clear, any other command sets ER1, is discarded, and leaves the state at stall, so the next fetched word is held and does not dispatch.
- R10: With ME1 set, an illegal command is discarded, ER1 stays clear, the state returns to idle and the next word dispatches normally.
- R11: `tag_mismatch` while a command is outstanding sets ER0 when ME0 (mask bit 1) is clear. The outstanding command still completes, and the stall is taken on the next word. With ME0 set, the mismatch has no effect.
- R12: A control write with bit 0 set clears ER0, ER1, INT, PIS and the resume flag, and discards the held word. The state becomes idle, or wait if a command is still outstanding.
- R13: Status bit positions are ER1 = 13, ER0 = 12, INT = 11, PIS = 10, with the state in bits 1:0 and all other bits zero. `host_wr_sel` = 0 addresses the control register and 1 addresses the mask register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset |
| fifo_word | input | 32 | Command word from the instruction FIFO |
| fifo_valid | input | 1 | FIFO word present |
| fifo_ready | output | 1 | Block takes the word this cycle |
| disp_valid | output | 1 | One-cycle command dispatch strobe |
| disp_cmd | output | 7 | Dispatched command field |
| disp_count | output | 8 | Dispatched count field |
| disp_imm | output | 16 | Dispatched immediate field |
| disp_done | input | 1 | Execution unit finished the outstanding command |
| tag_mismatch | input | 1 | Data/tag mismatch seen during operand fetch |
| host_wr_en | input | 1 | Host register write strobe |
| host_wr_sel | input | 1 | 0 = control register, 1 = error-mask register |
| host_wr_data | input | 4 | Host write data |
| status | output | 16 | Status flags and processing state |
| code_word | output | 32 | Last fetched command word |

## Verification
The bench builds the block with the default `MARK_CMD` of 0x07. This lets a plain marker word drive the path where an interrupt-flagged command executes and the stall falls on the following word. A scoreboard queue holds every command the bench expects to see dispatched, so any dispatch from a stalled state shows up as an unexpected item. The bench holds back `disp_done` to keep a command outstanding. That makes the wait state observable and gives a window in which to inject the tag mismatch under both mask settings.

// File: rtl/cic_pkg.sv
package cic_pkg;

  localparam int WORD_W = 32;
  localparam int CMD_W  = 7;
  localparam int CNT_W  = 8;
  localparam int IMM_W  = 16;
  localparam int STAT_W = 16;
  localparam int MASK_W = 3;
  localparam int HOST_W = 4;

  // status bit positions
  localparam int ST_ER1 = 13;
  localparam int ST_ER0 = 12;
  localparam int ST_INT = 11;
  localparam int ST_PIS = 10;

  // mask bit positions
  localparam int MSK_MII = 0;
  localparam int MSK_ME0 = 1;
  localparam int MSK_ME1 = 2;

  // control strobes
  localparam int CTL_RST = 0;
  localparam int CTL_CAN = 3;

  typedef enum logic [1:0] {
    PS_IDLE   = 2'd0,
    PS_WAIT   = 2'd1,
    PS_DECODE = 2'd2,
    PS_STALL  = 2'd3
  } pstate_e;

  typedef struct packed {
    logic             irq;
    logic [CMD_W-1:0] cmd;
    logic [CNT_W-1:0] cnt;
    logic [IMM_W-1:0] imm;
  } cmd_word_t;

  function automatic cmd_word_t split_word(input logic [WORD_W-1:0] w);
    return cmd_word_t'(w);
  endfunction

  function automatic logic cmd_is_legal(input logic [CMD_W-1:0] c);
    logic ok;
    ok = (c <= 7'h07);
    ok = ok | ((c >= 7'h10) && (c <= 7'h15));
    ok = ok | (c == 7'h17) | (c == 7'h20) | (c == 7'h30) | (c == 7'h31);
    ok = ok | (c == 7'h4A) | (c == 7'h50) | (c == 7'h51);
    ok = ok | (c[6:5] == 2'b11);
    return ok;
  endfunction

endpackage

// File: rtl/cic_fetch.sv
module cic_fetch
  import cic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] fifo_word,
  input  logic              fifo_valid,
  input  logic              busy,
  input  logic              ctl_wr,
  input  logic              flush,
  input  logic              consume,
  output logic              fifo_ready,
  output logic              accept,
  output logic              held,
  output logic [WORD_W-1:0] code_q
);

  assign fifo_ready = !held && !busy && !ctl_wr;
  assign accept     = fifo_valid && fifo_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q <= '0;
      held   <= 1'b0;
    end else if (accept) begin
      code_q <= fifo_word;
      held   <= 1'b1;
    end else if (consume || flush) begin
      held   <= 1'b0;
    end
  end

  // R2
  code_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (held && code_q == $past(fifo_word)));

endmodule

// File: rtl/cic_decide.sv
module cic_decide
  import cic_pkg::*;
#(
  parameter logic [CMD_W-1:0] MARK_CMD = 7'h07
)(
  input  logic             held,
  input  logic             busy,
  input  logic             ctl_wr,
  input  logic             irq,
  input  logic [CMD_W-1:0] cmd,
  input  logic             stall_any,
  input  logic             noloop,
  input  logic             mask_mii,
  output logic             ev_blocked,
  output logic             ev_intr_new,
  output logic             ev_intr_resume,
  output logic             ev_int_stall,
  output logic             ev_illegal,
  output logic             ev_dispatch,
  output logic             ev_consume
);

  logic issue, go, exec_ok, legal;

  always_comb begin
    issue          = held && !busy && !ctl_wr;
    go             = issue && !stall_any;
    ev_blocked     = issue && stall_any;
    ev_intr_new    = go && irq && !noloop;
    ev_intr_resume = go && irq && noloop;
    ev_int_stall   = ev_intr_new && !mask_mii && (cmd != MARK_CMD);
    exec_ok        = go && !ev_int_stall;
    legal          = cmd_is_legal(cmd);
    ev_illegal     = exec_ok && !legal;
    ev_dispatch    = exec_ok && legal;
    ev_consume     = exec_ok;
  end

endmodule

// File: rtl/cic_status.sv
module cic_status
  import cic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_blocked,
  input  logic              ev_intr_new,
  input  logic              ev_intr_resume,
  input  logic              ev_int_stall,
  input  logic              ev_illegal,
  input  logic              ev_dispatch,
  input  logic              accept,
  input  logic              ctl_reset,
  input  logic              ctl_cancel,
  input  logic              mask_wr,
  input  logic [MASK_W-1:0] mask_data,
  input  logic              disp_done,
  input  logic              tag_mismatch,
  output logic [STAT_W-1:0] status_word,
  output logic              stall_any,
  output logic              noloop,
  output logic              mask_mii,
  output logic              busy,
  output logic              fire
);

  logic              er0, er1, intf, pis;
  logic [MASK_W-1:0] mask;
  pstate_e           pstate, pstate_n;
  logic              done_ev;

  assign done_ev   = busy && disp_done;
  assign stall_any = er0 || er1 || pis;
  assign mask_mii  = mask[MSK_MII];

  always_comb begin
    pstate_n = pstate;
    if (ctl_reset)
      pstate_n = (busy && !disp_done) ? PS_WAIT : PS_IDLE;
    else if (ctl_cancel && pstate == PS_STALL)
      pstate_n = PS_IDLE;
    else if (ev_blocked || ev_int_stall)
      pstate_n = PS_STALL;
    else if (ev_illegal)
      pstate_n = mask[MSK_ME1] ? PS_IDLE : PS_STALL;
    else if (ev_dispatch)
      pstate_n = PS_WAIT;
    else if (done_ev)
      pstate_n = PS_IDLE;
    else if (accept && pstate == PS_IDLE)
      pstate_n = PS_DECODE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      er0    <= 1'b0;
      er1    <= 1'b0;
      intf   <= 1'b0;
      pis    <= 1'b0;
      noloop <= 1'b0;
      busy   <= 1'b0;
      fire   <= 1'b0;
      mask   <= '0;
      pstate <= PS_IDLE;
    end else begin
      pstate <= pstate_n;
      fire   <= ev_dispatch;
      if (mask_wr) mask <= mask_data;
      if (ev_dispatch)  busy <= 1'b1;
      else if (done_ev) busy <= 1'b0;
      if (ctl_reset) begin
        er0    <= 1'b0;
        er1    <= 1'b0;
        intf   <= 1'b0;
        pis    <= 1'b0;
        noloop <= 1'b0;
      end else begin
        if (busy && tag_mismatch && !mask[MSK_ME0]) er0 <= 1'b1;
        if (ev_intr_new) begin
          intf <= 1'b1;
          if (!mask[MSK_MII]) pis <= 1'b1;
        end
        if (ev_int_stall)   noloop <= 1'b1;
        if (ev_intr_resume) noloop <= 1'b0;
        if (ev_illegal && !mask[MSK_ME1]) er1 <= 1'b1;
        if (ctl_cancel) begin
          pis  <= 1'b0;
          intf <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    status_word         = '0;
    status_word[ST_ER1] = er1;
    status_word[ST_ER0] = er0;
    status_word[ST_INT] = intf;
    status_word[ST_PIS] = pis;
    status_word[1:0]    = pstate;
  end

  // R4
  no_issue_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> $past(!stall_any));

  // R3
  dispatch_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dispatch |=> (busy && pstate == PS_WAIT));

  // R5
  int_stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_int_stall |=> (pstate == PS_STALL && pis && intf && noloop));

  // R8
  cancel_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_cancel && !ctl_reset) |=> (!pis && !intf));

  // R10
  masked_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_illegal && mask[MSK_ME1]) |=> (!er1 && pstate == PS_IDLE));

  // R11
  masked_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tag_mismatch && mask[MSK_ME0] && !er0 && !mask_wr) |=> !er0);

  // R1
  single_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);

endmodule

// File: rtl/cmd_issue_ctrl.sv
module cmd_issue_ctrl
  import cic_pkg::*;
#(
  parameter logic [CMD_W-1:0] MARK_CMD = 7'h07
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] fifo_word,
  input  logic              fifo_valid,
  output logic              fifo_ready,
  output logic              disp_valid,
  output logic [CMD_W-1:0]  disp_cmd,
  output logic [CNT_W-1:0]  disp_count,
  output logic [IMM_W-1:0]  disp_imm,
  input  logic              disp_done,
  input  logic              tag_mismatch,
  input  logic              host_wr_en,
  input  logic              host_wr_sel,
  input  logic [HOST_W-1:0] host_wr_data,
  output logic [STAT_W-1:0] status,
  output logic [WORD_W-1:0] code_word
);

  logic      ctl_wr, ctl_reset, ctl_cancel, mask_wr;
  logic      accept, held, busy, stall_any, noloop, mask_mii;
  logic      ev_blocked, ev_intr_new, ev_intr_resume, ev_int_stall;
  logic      ev_illegal, ev_dispatch, ev_consume;
  cmd_word_t fields;

  assign ctl_wr     = host_wr_en && !host_wr_sel;
  assign ctl_reset  = ctl_wr && host_wr_data[CTL_RST];
  assign ctl_cancel = ctl_wr && host_wr_data[CTL_CAN];
  assign mask_wr    = host_wr_en && host_wr_sel;
  assign fields     = split_word(code_word);

  assign disp_cmd   = fields.cmd;
  assign disp_count = fields.cnt;
  assign disp_imm   = fields.imm;

  cic_fetch u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_word  (fifo_word),
    .fifo_valid (fifo_valid),
    .busy       (busy),
    .ctl_wr     (ctl_wr),
    .flush      (ctl_reset),
    .consume    (ev_consume),
    .fifo_ready (fifo_ready),
    .accept     (accept),
    .held       (held),
    .code_q     (code_word)
  );

  cic_decide #(.MARK_CMD(MARK_CMD)) u_decide (
    .held           (held),
    .busy           (busy),
    .ctl_wr         (ctl_wr),
    .irq            (fields.irq),
    .cmd            (fields.cmd),
    .stall_any      (stall_any),
    .noloop         (noloop),
    .mask_mii       (mask_mii),
    .ev_blocked     (ev_blocked),
    .ev_intr_new    (ev_intr_new),
    .ev_intr_resume (ev_intr_resume),
    .ev_int_stall   (ev_int_stall),
    .ev_illegal     (ev_illegal),
    .ev_dispatch    (ev_dispatch),
    .ev_consume     (ev_consume)
  );

  cic_status u_status (
    .clk            (clk),
    .rst_n          (rst_n),
    .ev_blocked     (ev_blocked),
    .ev_intr_new    (ev_intr_new),
    .ev_intr_resume (ev_intr_resume),
    .ev_int_stall   (ev_int_stall),
    .ev_illegal     (ev_illegal),
    .ev_dispatch    (ev_dispatch),
    .accept         (accept),
    .ctl_reset      (ctl_reset),
    .ctl_cancel     (ctl_cancel),
    .mask_wr        (mask_wr),
    .mask_data      (host_wr_data[MASK_W-1:0]),
    .disp_done      (disp_done),
    .tag_mismatch   (tag_mismatch),
    .status_word    (status),
    .stall_any      (stall_any),
    .noloop         (noloop),
    .mask_mii       (mask_mii),
    .busy           (busy),
    .fire           (disp_valid)
  );

  // R6
  marker_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_intr_new && fields.cmd == MARK_CMD && !stall_any) |=> disp_valid);

  // R9
  illegal_no_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_illegal |=> !disp_valid);

endmodule

// File: tb/cmd_issue_ctrl_test.sv
module cmd_issue_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fifo_word = '0;
  logic        fifo_valid = 1'b0;
  logic        fifo_ready;
  logic        disp_valid;
  logic [6:0]  disp_cmd;
  logic [7:0]  disp_count;
  logic [15:0] disp_imm;
  logic        disp_done = 1'b0;
  logic        tag_mismatch = 1'b0;
  logic        host_wr_en = 1'b0;
  logic        host_wr_sel = 1'b0;
  logic [3:0]  host_wr_data = '0;
  logic [15:0] status;
  logic [31:0] code_word;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  finished = 0;
  bit  hold_done = 0;
  bit  pend = 0;
  logic [30:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_issue_ctrl uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .fifo_word    (fifo_word),
    .fifo_valid   (fifo_valid),
    .fifo_ready   (fifo_ready),
    .disp_valid   (disp_valid),
    .disp_cmd     (disp_cmd),
    .disp_count   (disp_count),
    .disp_imm     (disp_imm),
    .disp_done    (disp_done),
    .tag_mismatch (tag_mismatch),
    .host_wr_en   (host_wr_en),
    .host_wr_sel  (host_wr_sel),
    .host_wr_data (host_wr_data),
    .status       (status),
    .code_word    (code_word)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected dispatch = word fields below the interrupt flag
  task automatic expect_cmd(input logic [31:0] w);
    exp_q.push_back(w[30:0]);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_word(input logic [31:0] w);
    @(negedge clk);
    while (!fifo_ready) @(negedge clk);
    fifo_word  = w;
    fifo_valid = 1'b1;
    @(negedge clk);
    fifo_valid = 1'b0;
  endtask

  task automatic host_ctl(input logic [3:0] d);
    @(negedge clk);
    host_wr_en = 1'b1; host_wr_sel = 1'b0; host_wr_data = d;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic host_mask(input logic [3:0] d);
    @(negedge clk);
    host_wr_en = 1'b1; host_wr_sel = 1'b1; host_wr_data = d;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic pulse_tag();
    @(negedge clk);
    tag_mismatch = 1'b1;
    @(negedge clk);
    tag_mismatch = 1'b0;
  endtask

  // execution unit model: answers done once per dispatch
  initial forever begin
    @(negedge clk);
    disp_done = 1'b0;
    if (disp_valid) pend = 1;
    if (pend && !hold_done) begin
      disp_done = 1'b1;
      pend = 0;
    end
  end

  // scoreboard monitor (R1, R4)
  initial forever begin
    @(negedge clk);
    if (rst_n && disp_valid) begin
      n_checks++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R4: actual=dispatch %h expected=none", {disp_cmd, disp_count, disp_imm});
      end else begin
        logic [30:0] e;
        e = exp_q.pop_front();
        if ({disp_cmd, disp_count, disp_imm} !== e) begin
          n_fail++;
          $display("FAIL R1: actual=%h expected=%h", {disp_cmd, disp_count, disp_imm}, e);
        end
      end
    end
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL R3 watchdog: actual=hung expected=complete");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state (R13, R3, R2)
    check("R13 reset status", {16'h0, status}, 32'h0);
    check("R2 reset code", code_word, 32'h0);
    check("R2 reset ready", {31'h0, fifo_ready}, 32'h1);
    check("R1 reset no dispatch", {31'h0, disp_valid}, 32'h0);

    // normal command with state walk (R1, R2, R3)
    hold_done = 1;
    expect_cmd(32'h05123456);
    @(negedge clk);
    fifo_word = 32'h05123456; fifo_valid = 1'b1;
    @(negedge clk);
    fifo_valid = 1'b0;
    check("R3 decode after accept", {30'h0, status[1:0]}, 32'h2);
    check("R2 code captured", code_word, 32'h05123456);
    @(negedge clk);
    check("R3 wait after dispatch", {30'h0, status[1:0]}, 32'h1);
    check("R1 strobe high", {31'h0, disp_valid}, 32'h1);
    idle(3);
    check("R1 strobe single", {31'h0, disp_valid}, 32'h0);
    check("R2 not ready while outstanding", {31'h0, fifo_ready}, 32'h0);
    check("R3 still waiting", {30'h0, status[1:0]}, 32'h1);
    hold_done = 0;
    idle(3);
    check("R3 idle after done", {16'h0, status}, 32'h0);

    // interrupt word, MII clear (R5, R8, R13)
    push_word(32'h85000000);
    idle(3);
    check("R5 int stall status", {16'h0, status}, 32'h0C03);
    check("R5 code held", code_word, 32'h85000000);
    check("R5 word held", {31'h0, fifo_ready}, 32'h0);
    check("R4 nothing dispatched", exp_q.size(), 0);
    expect_cmd(32'h85000000);
    host_ctl(4'b1000);
    idle(4);
    check("R8 resumed, no new INT", {16'h0, status}, 32'h0);
    check("R8 resumed command ran", exp_q.size(), 0);

    // interrupt marker (R6, R4)
    expect_cmd(32'h8700B00F);
    push_word(32'h8700B00F);
    idle(3);
    push_word(32'h0000000F);
    idle(3);
    check("R6 stall after marker", {16'h0, status}, 32'h0C03);
    check("R6 next word held", code_word, 32'h0000000F);
    check("R6 marker ran alone", exp_q.size(), 0);
    expect_cmd(32'h0000000F);
    host_ctl(4'b1000);
    idle(4);
    check("R8 cancel releases word", {16'h0, status}, 32'h0);

    // MII masked (R7, R12)
    host_mask(4'b0001);
    expect_cmd(32'h85000000);
    push_word(32'h85000000);
    idle(4);
    check("R7 INT only, ran", {16'h0, status}, 32'h0800);
    check("R7 dispatched", exp_q.size(), 0);
    host_ctl(4'b0001);
    idle(1);
    check("R12 reset clears INT", {16'h0, status}, 32'h0);
    host_mask(4'b0000);

    // illegal, ME1 clear (R9, R8, R12)
    push_word(32'h08000000);
    idle(3);
    check("R9 ER1 stall", {16'h0, status}, 32'h2003);
    push_word(32'h01000001);
    idle(3);
    check("R9 next word fetched", code_word, 32'h01000001);
    check("R9 still stalled", {16'h0, status}, 32'h2003);
    host_ctl(4'b1000);
    idle(3);
    check("R8 cancel keeps ER1", {16'h0, status}, 32'h2003);
    host_ctl(4'b0001);
    idle(2);
    check("R12 reset clears ER1", {16'h0, status}, 32'h0);
    check("R12 held word dropped", {31'h0, fifo_ready}, 32'h1);

    // illegal, ME1 set (R10)
    host_mask(4'b0100);
    push_word(32'h40000000);
    idle(3);
    check("R10 skipped, idle", {16'h0, status}, 32'h0);
    expect_cmd(32'h00000002);
    push_word(32'h00000002);
    idle(4);
    check("R10 next ran", exp_q.size(), 0);

    // tag mismatch, ME0 clear (R11)
    host_mask(4'b0000);
    hold_done = 1;
    expect_cmd(32'h30000000);
    push_word(32'h30000000);
    idle(2);
    pulse_tag();
    idle(1);
    hold_done = 0;
    idle(3);
    check("R11 ER0 after completion", {16'h0, status}, 32'h1000);
    push_word(32'h00000003);
    idle(3);
    check("R11 stall on next word", {16'h0, status}, 32'h1003);
    check("R11 next word held", code_word, 32'h00000003);
    host_ctl(4'b0001);
    idle(2);
    check("R12 reset clears ER0", {16'h0, status}, 32'h0);

    // tag mismatch, ME0 set (R11)
    host_mask(4'b0010);
    hold_done = 1;
    expect_cmd(32'h31000000);
    push_word(32'h31000000);
    idle(2);
    pulse_tag();
    idle(1);
    hold_done = 0;
    idle(3);
    check("R11 masked no ER0", {16'h0, status}, 32'h0);
    expect_cmd(32'h00000004);
    push_word(32'h00000004);
    idle(4);

    check("R4 scoreboard drained", exp_q.size(), 0);
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule